// File: doc/BRIEF.md
# Four-Channel One-Shot Alarm Unit

This unit holds four independent one-shot alarms. Each is compared, on every clock, with the low 32 bits of a free-running microsecond count. That count is kept outside the unit and arrives on an input. Software sets an alarm by writing its target word. The write also arms the channel.

An armed channel whose target matches the count fires. Firing disarms the channel and latches a raw interrupt bit. Software can cancel pending alarms by writing ones to the armed-status word. Each raw bit is gated by an enable bit and may be overridden by a force bit. The result appears both as a readable status word and on one interrupt line per channel.

Register access is a simple single-cycle port. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `alarm_irq_unit`

## Requirements
- R1: A write to byte offset 0x10 + 4*n (n = 0..3) stores the 32-bit target of channel n. Reading the same offset returns it.
- R2: A target write sets the channel's armed flag. The armed flags read at offset 0x20 in bits 3:0, bit n for channel n.
- R3: An armed channel whose target equals `timeLow` at a clock edge fires there. After that edge its armed flag is 0 and its raw bit is 1. An unarmed channel never sets its raw bit, whatever the count.
- R4: Writing a 1 to bit n at offset 0x20 clears armed flag n at the edge, without setting raw bit n.
- R5: The raw interrupt word at offset 0x34 (bits 3:0) clears each bit written as 1. Bits written as 0 are unchanged.
- R6: If a channel fires in the same cycle that its raw bit is written with 1, the raw bit ends up set.
- R7: If a channel fires in the same cycle that its target is rewritten, the raw bit sets, the new target is stored, and the channel stays armed.
- R8: The enable (0x38) and force (0x3C) words are read/write in bits 3:0. The status word at 0x40 reads (raw AND enable) OR force. `irq[n]` equals status bit n.
- R9: After reset all targets, armed flags, raw, enable and force bits are 0, and `irq` is 0.
- R10: Unmapped or misaligned addresses read 0. Bits above bit 3 of the flag words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| timeLow | input | 32 | Low word of the external microsecond count |
| regAddr | input | 8 | Byte address of the register access |
| regWe | input | 1 | Write strobe for the current address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for `regAddr` |
| irq | output | 4 | Per-channel interrupt, equal to the status bits |

## Verification
On every cycle, the in-line properties check the per-channel flag transitions: firing clears the armed flag and sets the raw bit, an idle unarmed channel can never raise its raw bit, a target write arms with the written value, cancel is silent, and write-one-to-clear takes effect. The overall readback map, the priority cases where two updates land in the same cycle, and the masking and forcing as seen on `irq` can only be shown by the bench's scenarios. Those scenarios drive the count to exact target values and read the registers through the port.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int NCH  = 4;
  localparam int CH_W = $clog2(NCH);

  // Byte offsets; the target window base is aligned to 4*NCH.
  localparam int OFS_TGT0  = 'h10;
  localparam int OFS_ARMED = 'h20;
  localparam int OFS_RAW   = 'h34;
  localparam int OFS_EN    = 'h38;
  localparam int OFS_FRC   = 'h3C;
  localparam int OFS_STAT  = 'h40;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TGT, SEL_ARMED, SEL_RAW, SEL_EN, SEL_FRC, SEL_STAT
  } rdSel_e;

  typedef struct packed {
    logic [NCH-1:0] tgtWr;
    logic [NCH-1:0] armClr;
    logic [NCH-1:0] rawClr;
    logic           enWr;
    logic           frcWr;
  } strobe_t;
endpackage

// File: rtl/alarm_cmp_ctrl.sv
module alarm_cmp_ctrl
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [NCH-1:0]    wrLow,
  output strobe_t           strobe,
  output rdSel_e            rdSel,
  output logic [CH_W-1:0]   rdIdx
);
  localparam logic [ADDR_W-1:0] A_TGT0  = ADDR_W'(OFS_TGT0);
  localparam logic [ADDR_W-1:0] A_TGTE  = ADDR_W'(OFS_TGT0 + 4 * NCH);
  localparam logic [ADDR_W-1:0] A_ARMED = ADDR_W'(OFS_ARMED);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_FRC   = ADDR_W'(OFS_FRC);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

  logic inTgt;

  always_comb begin
    inTgt = (regAddr >= A_TGT0) && (regAddr < A_TGTE) && (regAddr[1:0] == 2'b00);
    rdIdx = regAddr[CH_W+1:2];

    if (inTgt)                   rdSel = SEL_TGT;
    else if (regAddr == A_ARMED) rdSel = SEL_ARMED;
    else if (regAddr == A_RAW)   rdSel = SEL_RAW;
    else if (regAddr == A_EN)    rdSel = SEL_EN;
    else if (regAddr == A_FRC)   rdSel = SEL_FRC;
    else if (regAddr == A_STAT)  rdSel = SEL_STAT;
    else                         rdSel = SEL_NONE;

    strobe        = '0;
    strobe.tgtWr  = (regWe && inTgt) ? (NCH'(1) << rdIdx) : '0;
    strobe.armClr = (regWe && rdSel == SEL_ARMED) ? wrLow : '0;
    strobe.rawClr = (regWe && rdSel == SEL_RAW) ? wrLow : '0;
    strobe.enWr   = regWe && (rdSel == SEL_EN);
    strobe.frcWr  = regWe && (rdSel == SEL_FRC);
  end
endmodule

// File: rtl/alarm_cmp_dp.sv
module alarm_cmp_dp
  import alarm_cmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] timeLow,
  input  logic [DATA_W-1:0] regWdata,
  input  strobe_t           strobe,
  input  rdSel_e            rdSel,
  input  logic [CH_W-1:0]   rdIdx,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    irq
);
  logic [DATA_W-1:0] targetQ [NCH];
  logic [NCH-1:0]    armedQ, rawQ, enQ, frcQ;
  logic [NCH-1:0]    match, fire, status;

  for (genvar g = 0; g < NCH; g++) begin : gCh
    assign match[g] = (targetQ[g] == timeLow);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                targetQ[g] <= '0;
      else if (strobe.tgtWr[g]) targetQ[g] <= regWdata;
    end

    AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
      (armedQ[g] && match[g] && !strobe.tgtWr[g]) |=> !armedQ[g]); // R3
    AST_IDLE_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (!armedQ[g] && !rawQ[g]) |=> !rawQ[g]); // R3
    AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      strobe.tgtWr[g] |=> (armedQ[g] && targetQ[g] == $past(regWdata))); // R2
    AST_CANCEL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.armClr[g] && !match[g] && !strobe.tgtWr[g] && !rawQ[g]) |=> (!armedQ[g] && !rawQ[g])); // R4
    AST_W1C_RAW: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.rawClr[g] && !(armedQ[g] && match[g])) |=> !rawQ[g]); // R5
    AST_FIRE_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (armedQ[g] && match[g]) |=> rawQ[g]); // R6
  end

  assign fire   = armedQ & match;
  assign status = (rawQ & enQ) | frcQ;
  assign irq    = status;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= '0;
      rawQ   <= '0;
      enQ    <= '0;
      frcQ   <= '0;
    end else begin
      // arm beats both fire and cancel; fire beats clear
      armedQ <= (armedQ & ~fire & ~strobe.armClr) | strobe.tgtWr;
      rawQ   <= (rawQ & ~strobe.rawClr) | fire;
      if (strobe.enWr)  enQ  <= regWdata[NCH-1:0];
      if (strobe.frcWr) frcQ <= regWdata[NCH-1:0];
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_TGT:   rdata = targetQ[rdIdx];
      SEL_ARMED: rdata = DATA_W'(armedQ);
      SEL_RAW:   rdata = DATA_W'(rawQ);
      SEL_EN:    rdata = DATA_W'(enQ);
      SEL_FRC:   rdata = DATA_W'(frcQ);
      SEL_STAT:  rdata = DATA_W'(status);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] timeLow,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [NCH-1:0]    irq
);
  strobe_t         strobe;
  rdSel_e          rdSel;
  logic [CH_W-1:0] rdIdx;

  alarm_cmp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .wrLow   (regWdata[NCH-1:0]),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .rdIdx   (rdIdx)
  );

  alarm_cmp_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .timeLow  (timeLow),
    .regWdata (regWdata),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .rdIdx    (rdIdx),
    .rdata    (regRdata),
    .irq      (irq)
  );

  AST_IRQ_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irq == '0)); // R9
endmodule

// File: tb/alarm_irq_unit_bench.sv
module alarm_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] timeLow = '0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  alarm_irq_unit u_alarm_irq_unit (
    .clk(clk), .rstN(rstN), .timeLow(timeLow), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;  // write data or expected read value
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 8'h10, 32'h0000_0100, 4'd1},
    '{1'b1, 8'h14, 32'hDEAD_0200, 4'd1},
    '{1'b0, 8'h10, 32'h0000_0100, 4'd1},   // R1
    '{1'b0, 8'h14, 32'hDEAD_0200, 4'd1},   // R1
    '{1'b0, 8'h20, 32'h0000_0003, 4'd2},   // R2
    '{1'b1, 8'h38, 32'hFFFF_FFFF, 4'd8},
    '{1'b0, 8'h38, 32'h0000_000F, 4'd8},   // R8 and R10 upper bits
    '{1'b1, 8'h3C, 32'h0000_0005, 4'd8},
    '{1'b0, 8'h40, 32'h0000_0005, 4'd8},   // R8 force only
    '{1'b1, 8'h3C, 32'h0000_0000, 4'd8},
    '{1'b0, 8'h1C, 32'h0000_0000, 4'd9},   // R9 untouched target
    '{1'b0, 8'h44, 32'h0000_0000, 4'd10},  // R10 unmapped
    '{1'b0, 8'h12, 32'h0000_0000, 4'd10},  // R10 misaligned
    '{1'b1, 8'h20, 32'h0000_0003, 4'd4},
    '{1'b0, 8'h20, 32'h0000_0000, 4'd4},   // R4 cancelled
    '{1'b0, 8'h34, 32'h0000_0000, 4'd4}    // R4 no raw set
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    tick();
    regWe = 1'b0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    chk(req, regRdata, exp);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    rd(9, 8'h20, 32'h0);
    rd(9, 8'h34, 32'h0);
    rd(9, 8'h40, 32'h0);
    rd(9, 8'h10, 32'h0);
    chk(9, {28'h0, irq}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else           rd(int'(VEC[i].req), VEC[i].addr, VEC[i].data);
    end

    // R3: arm channel 2 at 50, count reaches 50
    wr(8'h18, 32'd50);
    rd(2, 8'h20, 32'h4);
    timeLow = 32'd50;
    #1;
    chk(3, {28'h0, irq}, 32'h0);
    tick();
    rd(3, 8'h20, 32'h0);
    rd(3, 8'h34, 32'h4);
    chk(3, {28'h0, irq}, 32'h4);

    // R5: clear raw bit 2; bit 2 written as 1, others 0
    wr(8'h34, 32'h4);
    rd(5, 8'h34, 32'h0);
    // R3: unarmed channel at a matching count stays quiet
    tick();
    rd(3, 8'h34, 32'h0);

    // R6: fire channel 0 while clearing its raw bit
    wr(8'h10, 32'd60);
    timeLow = 32'd60;
    wr(8'h34, 32'h1);
    rd(6, 8'h34, 32'h1);
    rd(6, 8'h20, 32'h0);

    // R7: channel 3 fires while its target is rewritten
    wr(8'h1C, 32'd80);
    timeLow = 32'd80;
    wr(8'h1C, 32'd90);
    rd(7, 8'h20, 32'h8);
    rd(7, 8'h34, 32'h9);
    rd(7, 8'h1C, 32'd90);

    // R8: masking and forcing on irq
    chk(8, {28'h0, irq}, 32'h9);
    wr(8'h38, 32'h1);
    chk(8, {28'h0, irq}, 32'h1);
    rd(8, 8'h40, 32'h1);
    wr(8'h3C, 32'h2);
    chk(8, {28'h0, irq}, 32'h3);
    rd(8, 8'h3C, 32'h2);

    report();
  end
endmodule